// File: doc/BRIEF.md
# Versioned ECC Controller Register File

This block holds the control and status registers of an ECC memory controller. Software reaches nine 32-bit words over a simple register port: a valid strobe, a write flag, a byte address and write data. The word index is the byte address shifted right by two. Read data is combinational and is returned in the same cycle as a read strobe. A build-time parameter picks one of three implementation variants. The variant sets the write mask of the enable register, the version code shown in its top byte, the bits that survive a warm reset, and whether a four-byte diagnostic window exists.

The controller's error checker reports a fault through a capture port. A capture loads the fault status word and both fault address words. It raises the interrupt output for every uncorrectable error. It raises the interrupt for a correctable error only while interrupts on correctable errors are enabled. Software lowers the interrupt by writing the status word.

There are two reset inputs. Power-on reset clears everything. Warm reset clears the registers but keeps the configuration bits of the enable register that the variant says to keep.

Top module: `ecc_csr_top`

## Requirements
- R1: Word indexes 0 to 8 select, in this order: enable, delay, status, video, fault address 0, fault address 1, diagnostic, event count 0, event count 1. Indexes 7 and 8 are separate storage. Each is written and read without affecting the other.
- R2: A read of a word index from 9 upward returns zero. A write to such an index changes no register.
- R3: On variant 0, an enable write stores `wdata & 0x00000103`. On variants 1 and 2, it stores `(wdata & 0x00000BFF) | (variant << 28)`. On variants 1 and 2, the top byte reads as `variant << 4` from power-on onward.
- R4: A delay write stores `wdata & 0x7FFFFFFF`, so bit 31 of the delay word always reads zero.
- R5: A write to the status word stores the full value. It drops the interrupt output in the following cycle, unless a fault is captured in the same cycle.
- R6: Writes to the two fault address words are ignored. Only fault capture changes them.
- R7: Under warm reset, variant 0 keeps only enable bit 8. Variants 1 and 2 keep enable bits 31:24, 11 and 9:2. All other enable bits clear.
- R8: After either reset, the delay word is 0x00000020 and fault address 0 is 0x07C00000. All other words are zero, except the bits kept under R7, and the interrupt is low. After power-on reset, enable holds only the version code.
- R9: On variant 0 only, an access with the window select high reaches a byte store. The byte is chosen by address bits 1:0. Writes take wdata bits 7:0, and reads return the byte zero-extended. On other variants, such reads return zero and such writes change nothing.
- R10: A fault capture loads the status word and both fault address words from the capture port. Capture raises the interrupt when the error is uncorrectable, or when it is correctable and enable bit 1 is set.
- R11: When a capture and a status write fall in the same cycle, the captured status is stored and the interrupt follows R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Synchronous power-on reset, active low |
| rstN | input | 1 | Synchronous warm reset, active low, keeps the variant's enable bits |
| busValid | input | 1 | Register access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| diagSel | input | 1 | Directs the access to the byte-wide diagnostic window |
| busAddr | input | ADDR_W | Byte address; bits above 1 give the word index |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of a read strobe, zero otherwise |
| faultValid | input | 1 | Fault capture strobe |
| faultUe | input | 1 | 1 = uncorrectable error, 0 = correctable |
| faultStatus | input | 32 | Status word to capture |
| faultAddr0 | input | 32 | Fault address word 0 to capture |
| faultAddr1 | input | 32 | Fault address word 1 to capture |
| irqOut | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are two. One is a fault capture landing in the same cycle as a status write. The other is a warm reset arriving after software has filled every enable bit. The stimulus builds both on purpose. It writes all ones to the enable word, pulses only the warm reset, and then reads every word back. It also drives a status write and a capture strobe together, with different data on each. A variant-0 instance and a variant-2 instance receive the same traffic, so each mask and window difference shows up as a mismatch between the two against the behavioural model.

// File: rtl/ecc_csr_pkg.sv
package ecc_csr_pkg;
  localparam int WORD_W    = 32;
  localparam int REG_COUNT = 9;
  localparam int DIAG_BYTES = 4;
  localparam int DIAG_IDX_W = $clog2(DIAG_BYTES);

  typedef enum logic [3:0] {
    IDX_ENABLE = 4'd0,
    IDX_DELAY  = 4'd1,
    IDX_STATUS = 4'd2,
    IDX_VIDEO  = 4'd3,
    IDX_FADDR0 = 4'd4,
    IDX_FADDR1 = 4'd5,
    IDX_DIAG   = 4'd6,
    IDX_COUNT0 = 4'd7,
    IDX_COUNT1 = 4'd8,
    IDX_NONE   = 4'd15
  } regIdx_e;

  typedef struct packed {
    logic      wrEnable;
    logic      wrDelay;
    logic      wrStatus;
    logic      wrVideo;
    logic      wrDiagReg;
    logic      wrCount0;
    logic      wrCount1;
    logic      wrDiagByte;
    logic [DIAG_IDX_W-1:0] diagByte;
    logic      rdActive;
    logic      rdDiag;
    regIdx_e   rdIdx;
  } csrStrobe_t;

  function automatic logic [WORD_W-1:0] versionCode(input int impl);
    return WORD_W'(impl) << 28;
  endfunction

  function automatic logic [WORD_W-1:0] enableWrMask(input int impl);
    return (impl == 0) ? 32'h0000_0103 : 32'h0000_0BFF;
  endfunction

  function automatic logic [WORD_W-1:0] enableKeepMask(input int impl);
    return (impl == 0) ? 32'h0000_0100 : 32'hFF00_0BFC;
  endfunction

  localparam logic [WORD_W-1:0] DELAY_MASK   = 32'h7FFF_FFFF;
  localparam logic [WORD_W-1:0] DELAY_RESET  = 32'h0000_0020;
  localparam logic [WORD_W-1:0] FADDR0_RESET = 32'h07C0_0000;
endpackage

// File: rtl/ecc_csr_ctrl.sv
module ecc_csr_ctrl
  import ecc_csr_pkg::*;
#(
  parameter int IMPL   = 0,
  parameter int ADDR_W = 6
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic              diagSel,
  input  logic [ADDR_W-1:0] busAddr,
  output csrStrobe_t        strobe
);
  localparam int  IDX_W    = ADDR_W - 2;
  localparam bit  HAS_DIAG = (IMPL == 0);

  logic [IDX_W-1:0] wordIdx;
  logic             mapped;
  logic             wordWr;
  regIdx_e          selIdx;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign mapped  = (int'(wordIdx) < REG_COUNT);
  assign selIdx  = mapped ? regIdx_e'(wordIdx[3:0]) : IDX_NONE;
  assign wordWr  = busValid && busWrite && !diagSel;

  always_comb begin
    strobe            = '0;
    strobe.rdIdx      = selIdx;
    strobe.diagByte   = busAddr[DIAG_IDX_W-1:0];
    strobe.rdActive   = busValid && !busWrite && !diagSel;
    strobe.rdDiag     = HAS_DIAG && busValid && !busWrite && diagSel;
    strobe.wrDiagByte = HAS_DIAG && busValid && busWrite && diagSel;
    if (wordWr) begin
      case (selIdx)
        IDX_ENABLE: strobe.wrEnable  = 1'b1;
        IDX_DELAY:  strobe.wrDelay   = 1'b1;
        IDX_STATUS: strobe.wrStatus  = 1'b1;
        IDX_VIDEO:  strobe.wrVideo   = 1'b1;
        IDX_DIAG:   strobe.wrDiagReg = 1'b1;
        IDX_COUNT0: strobe.wrCount0  = 1'b1;
        IDX_COUNT1: strobe.wrCount1  = 1'b1;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/ecc_csr_regs.sv
module ecc_csr_regs
  import ecc_csr_pkg::*;
#(
  parameter int IMPL = 0
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  csrStrobe_t        strobe,
  input  logic [WORD_W-1:0] wdata,
  input  logic              faultValid,
  input  logic              faultUe,
  input  logic [WORD_W-1:0] faultStatus,
  input  logic [WORD_W-1:0] faultAddr0,
  input  logic [WORD_W-1:0] faultAddr1,
  output logic [WORD_W-1:0] rdata,
  output logic              irq
);
  localparam logic [WORD_W-1:0] VCODE = versionCode(IMPL);
  localparam logic [WORD_W-1:0] WMASK = enableWrMask(IMPL);
  localparam logic [WORD_W-1:0] KMASK = enableKeepMask(IMPL);

  logic [WORD_W-1:0] enableQ, delayQ, statusQ, videoQ;
  logic [WORD_W-1:0] faddr0Q, faddr1Q, diagRegQ, count0Q, count1Q;
  logic [7:0]        diagRdByte;
  logic              anyReset;

  assign anyReset = !porN || !rstN;

  always_ff @(posedge clk) begin
    if (!porN)                enableQ <= VCODE;
    else if (!rstN)           enableQ <= enableQ & KMASK;
    else if (strobe.wrEnable) enableQ <= VCODE | (wdata & WMASK);
  end

  always_ff @(posedge clk) begin
    if (anyReset) begin
      delayQ   <= DELAY_RESET;
      statusQ  <= '0;
      videoQ   <= '0;
      faddr0Q  <= FADDR0_RESET;
      faddr1Q  <= '0;
      diagRegQ <= '0;
      count0Q  <= '0;
      count1Q  <= '0;
      irq      <= 1'b0;
    end else begin
      if (strobe.wrDelay)   delayQ   <= wdata & DELAY_MASK;
      if (strobe.wrVideo)   videoQ   <= wdata;
      if (strobe.wrDiagReg) diagRegQ <= wdata;
      if (strobe.wrCount0)  count0Q  <= wdata;
      if (strobe.wrCount1)  count1Q  <= wdata;
      if (faultValid) begin
        statusQ <= faultStatus;
        faddr0Q <= faultAddr0;
        faddr1Q <= faultAddr1;
        if (faultUe || enableQ[1]) irq <= 1'b1;
        else if (strobe.wrStatus)  irq <= 1'b0;
      end else if (strobe.wrStatus) begin
        statusQ <= wdata;
        irq     <= 1'b0;
      end
    end
  end

  generate
    if (IMPL == 0) begin : gDiag
      logic [7:0] diagBytes [DIAG_BYTES];
      always_ff @(posedge clk) begin
        if (anyReset) begin
          for (int i = 0; i < DIAG_BYTES; i++) diagBytes[i] <= '0;
        end else if (strobe.wrDiagByte) begin
          diagBytes[strobe.diagByte] <= wdata[7:0];
        end
      end
      assign diagRdByte = diagBytes[strobe.diagByte];
    end else begin : gNoDiag
      assign diagRdByte = '0;
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (strobe.rdDiag) begin
      rdata = {{(WORD_W-8){1'b0}}, diagRdByte};
    end else if (strobe.rdActive) begin
      case (strobe.rdIdx)
        IDX_ENABLE: rdata = enableQ;
        IDX_DELAY:  rdata = delayQ;
        IDX_STATUS: rdata = statusQ;
        IDX_VIDEO:  rdata = videoQ;
        IDX_FADDR0: rdata = faddr0Q;
        IDX_FADDR1: rdata = faddr1Q;
        IDX_DIAG:   rdata = diagRegQ;
        IDX_COUNT0: rdata = count0Q;
        IDX_COUNT1: rdata = count1Q;
        default:    rdata = '0;
      endcase
    end
  end

  p_status_clear_r5: assert property (@(posedge clk) disable iff (anyReset)
    strobe.wrStatus && !faultValid |=> !irq);

  p_ue_raise_r10: assert property (@(posedge clk) disable iff (anyReset)
    faultValid && faultUe |=> irq);

  p_ce_masked_r10: assert property (@(posedge clk) disable iff (anyReset)
    faultValid && !faultUe && !enableQ[1] && !irq |=> !irq);

  p_faddr_hold_r6: assert property (@(posedge clk) disable iff (anyReset)
    !faultValid |=> $stable(faddr0Q) && $stable(faddr1Q));

  p_delay_msb_r4: assert property (@(posedge clk) disable iff (anyReset)
    strobe.wrDelay |=> !delayQ[WORD_W-1]);
endmodule

// File: rtl/ecc_csr_top.sv
module ecc_csr_top
  import ecc_csr_pkg::*;
#(
  parameter int IMPL   = 1,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic              diagSel,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              faultValid,
  input  logic              faultUe,
  input  logic [31:0]       faultStatus,
  input  logic [31:0]       faultAddr0,
  input  logic [31:0]       faultAddr1,
  output logic              irqOut
);
  csrStrobe_t strobe;

  ecc_csr_ctrl #(.IMPL(IMPL), .ADDR_W(ADDR_W)) uCtrl (
    .busValid (busValid),
    .busWrite (busWrite),
    .diagSel  (diagSel),
    .busAddr  (busAddr),
    .strobe   (strobe)
  );

  ecc_csr_regs #(.IMPL(IMPL)) uRegs (
    .clk         (clk),
    .porN        (porN),
    .rstN        (rstN),
    .strobe      (strobe),
    .wdata       (busWdata),
    .faultValid  (faultValid),
    .faultUe     (faultUe),
    .faultStatus (faultStatus),
    .faultAddr0  (faultAddr0),
    .faultAddr1  (faultAddr1),
    .rdata       (busRdata),
    .irq         (irqOut)
  );
endmodule

// File: tb/tb_ecc_csr_top.sv
`timescale 1ns/1ps
module tb_ecc_csr_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic porN = 1'b0, rstN = 1'b0;
  logic busValid = 1'b0, busWrite = 1'b0, diagSel = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic faultValid = 1'b0, faultUe = 1'b0;
  logic [31:0] faultStatus = '0, faultAddr0 = '0, faultAddr1 = '0;
  logic [31:0] rdataA, rdataB;
  logic irqA, irqB;

  int testsRun = 0;
  int testsFailed = 0;
  string curReq = "R8";

  ecc_csr_top #(.IMPL(0), .ADDR_W(6)) dut (
    .clk(clk), .porN(porN), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .diagSel(diagSel), .busAddr(busAddr), .busWdata(busWdata), .busRdata(rdataA),
    .faultValid(faultValid), .faultUe(faultUe), .faultStatus(faultStatus),
    .faultAddr0(faultAddr0), .faultAddr1(faultAddr1), .irqOut(irqA));

  ecc_csr_top #(.IMPL(2), .ADDR_W(6)) dutAlt (
    .clk(clk), .porN(porN), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .diagSel(diagSel), .busAddr(busAddr), .busWdata(busWdata), .busRdata(rdataB),
    .faultValid(faultValid), .faultUe(faultUe), .faultStatus(faultStatus),
    .faultAddr0(faultAddr0), .faultAddr1(faultAddr1), .irqOut(irqB));

  // Behavioural model: [0] is variant 0, [1] is variant 2
  logic [31:0] mReg  [2][9];
  logic [7:0]  mDiag [2][4];
  logic        mIrq  [2];

  function automatic int implOf(input int k);
    return (k == 0) ? 0 : 2;
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      int im;
      int idx;
      logic [31:0] code;
      logic [31:0] oldEn;
      im = implOf(k);
      code = 32'(im) << 28;
      oldEn = mReg[k][0];
      idx = int'(busAddr) / 4;
      if (!porN || !rstN) begin
        if (!porN) mReg[k][0] = code;
        else mReg[k][0] = oldEn & ((im == 0) ? 32'h100 : 32'hFF000BFC);
        mReg[k][1] = 32'h20; mReg[k][2] = 0; mReg[k][3] = 0;
        mReg[k][4] = 32'h07C00000; mReg[k][5] = 0; mReg[k][6] = 0;
        mReg[k][7] = 0; mReg[k][8] = 0;
        for (int b = 0; b < 4; b++) mDiag[k][b] = 0;
        mIrq[k] = 0;
      end else begin
        if (busValid && busWrite) begin
          if (diagSel) begin
            if (im == 0) mDiag[k][busAddr % 4] = busWdata[7:0];
          end else begin
            case (idx)
              0: mReg[k][0] = (im == 0) ? (busWdata & 32'h103) : (code | (busWdata & 32'hBFF));
              1: mReg[k][1] = busWdata & 32'h7FFFFFFF;
              2: begin mReg[k][2] = busWdata; mIrq[k] = 0; end
              3, 6, 7, 8: mReg[k][idx] = busWdata;
              default: ;
            endcase
          end
        end
        if (faultValid) begin
          mReg[k][2] = faultStatus;
          mReg[k][4] = faultAddr0;
          mReg[k][5] = faultAddr1;
          if (faultUe || oldEn[1]) mIrq[k] = 1;
        end
      end
    end
  end

  function automatic logic [31:0] expRead(input int k);
    int idx;
    idx = int'(busAddr) / 4;
    if (!busValid || busWrite) return 0;
    if (diagSel) return (implOf(k) == 0) ? {24'b0, mDiag[k][busAddr % 4]} : 32'h0;
    if (idx < 9) return mReg[k][idx];
    return 0;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (porN && rstN) begin
      check(curReq, "variant0 rdata", rdataA, expRead(0));
      check(curReq, "variant2 rdata", rdataB, expRead(1));
      check(curReq, "variant0 irq", {31'b0, irqA}, {31'b0, mIrq[0]});
      check(curReq, "variant2 irq", {31'b0, irqB}, {31'b0, mIrq[1]});
    end
  end

  task automatic idle();
    busValid = 0; busWrite = 0; diagSel = 0; faultValid = 0;
    @(posedge clk); #1;
  endtask

  task automatic wr(input int addr, input logic [31:0] data, input logic dsel);
    busValid = 1; busWrite = 1; diagSel = dsel; busAddr = 6'(addr); busWdata = data;
    @(posedge clk); #1;
    busValid = 0; busWrite = 0; diagSel = 0;
  endtask

  task automatic rd(input int addr, input logic dsel);
    busValid = 1; busWrite = 0; diagSel = dsel; busAddr = 6'(addr);
    @(posedge clk); #1;
    busValid = 0; diagSel = 0;
  endtask

  task automatic readAll();
    for (int i = 0; i < 16; i++) rd(i * 4, 1'b0);
  endtask

  task automatic fault(input logic ue, input logic [31:0] st, input logic [31:0] a0, input logic [31:0] a1);
    faultValid = 1; faultUe = ue; faultStatus = st; faultAddr0 = a0; faultAddr1 = a1;
    @(posedge clk); #1;
    faultValid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; porN = 1; rstN = 1;
    curReq = "R8"; readAll();

    curReq = "R3";
    wr(0, 32'hFFFF_FFFF, 0); rd(0, 0);
    wr(0, 32'h0000_0A5A, 0); rd(0, 0);

    curReq = "R4";
    wr(4, 32'hFFFF_FFFF, 0); rd(4, 0);

    curReq = "R1";
    wr(12, 32'h1111_3333, 0); wr(24, 32'h6666_0006, 0);
    wr(28, 32'h7777_0007, 0); wr(32, 32'h8888_0008, 0);
    readAll();
    wr(28, 32'hDEAD_BEEF, 0); rd(32, 0); rd(28, 0);

    curReq = "R2";
    for (int i = 9; i < 16; i++) wr(i * 4, 32'hCAFE_0000 + 32'(i), 0);
    readAll();

    curReq = "R6";
    wr(16, 32'h1234_5678, 0); wr(20, 32'h9ABC_DEF0, 0); rd(16, 0); rd(20, 0);

    curReq = "R9";
    for (int b = 0; b < 4; b++) wr(b, 32'hA0 + 32'(b * 17), 1);
    for (int b = 0; b < 4; b++) rd(b, 1);
    rd(24, 0);

    curReq = "R10";
    wr(0, 32'h0, 0);
    fault(0, 32'h0000_AB01, 32'h0000_0F12, 32'h4000_1000); idle(); rd(8, 0); rd(16, 0); rd(20, 0);
    wr(0, 32'h2, 0);
    fault(0, 32'h0000_CD01, 32'h0000_0123, 32'h5000_2000); idle(); rd(8, 0);

    curReq = "R5";
    wr(8, 32'h0001_0F0F, 0); idle(); rd(8, 0);

    curReq = "R10";
    wr(0, 32'h0, 0);
    fault(1, 32'h0000_0008, 32'h0000_0456, 32'h6000_3000); idle(); rd(16, 0);

    curReq = "R11";
    busValid = 1; busWrite = 1; busAddr = 6'd8; busWdata = 32'h5555_5555;
    fault(1, 32'h0000_0018, 32'h0000_0789, 32'h7000_4000);
    busValid = 0; busWrite = 0;
    idle(); rd(8, 0);

    curReq = "R7";
    wr(0, 32'hFFFF_FFFF, 0); wr(4, 32'h0000_1234, 0);
    rstN = 0; @(posedge clk); #1; rstN = 1;
    readAll();
    wr(0, 32'h0000_0104, 0);
    rstN = 0; @(posedge clk); #1; rstN = 1;
    rd(0, 0);

    curReq = "R8";
    porN = 0; @(posedge clk); #1; porN = 1;
    readAll();
    idle();

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule